// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the slave side of a 4 Kbit serial memory that is reached over a three-wire Microwire link. A chip select, a serial clock and a serial data line come in, and the block samples them with its own system clock. While chip select is high it searches for a start bit. It then collects a two-bit opcode and an address and decodes one of seven instructions. Reads are answered on the serial output, one word after another, for as long as chip select stays high. The storage is an internal byte array. The organization input picks whether the link sees 512 bytes or 256 sixteen-bit words.

Programming commands are not timed here. On the falling edge of chip select the block raises a one-cycle command pulse with a command code, an address and data, for an external controller that handles the enable latch, programming delay and busy status. That controller returns a single permission level, `prog_ok`. When `prog_ok` is high at commit time, the internal array takes the new contents in the same cycle as the pulse.

Top module: `mw_eeprom_front`

## Requirements
- R1: After reset every byte of the array holds FFh, `doe` and `cmd_valid` are low, and a read returns all ones in either organization.
- R2: With chip select high, `di` is sampled on each rising serial clock edge, and zeros are skipped until the first 1, which is taken as the start bit.
- R3: Opcode 10 reads, 01 writes and 11 erases one location. Opcode 00 uses the two most significant address bits: 11 enable, 00 disable, 10 erase all, 01 write all. The `cmd_code` values are write=1, erase=2, erase all=3, write all=4, enable=5, disable=6.
- R4: With `org`=0 the address is 9 bits and the data 8 bits. With `org`=1 the address is 8 bits and the data 16 bits. Both are sent MSB first, and an 8-bit value appears in `cmd_data[7:0]`.
- R5: On a read, the rising edge that carries the last address bit makes `doe` high with `dout`=0 (a dummy bit). Each following rising edge puts out the next data bit, MSB first.
- R6: While chip select stays high, the read address steps after each word and the next word follows with no dummy bit. Byte address 511 wraps to 0, and word address 255 wraps to 0.
- R7: A non-read command is committed on the chip select falling edge only if the rising edges counted from the start bit (start bit included) number exactly 3+address bits, or 3+address+data bits for write and write all. Otherwise no `cmd_valid` is raised.
- R8: A committed command with `prog_ok` high changes the array. Write replaces the location. Erase sets it to ones. Erase all sets every byte to ones. Write all ANDs the data into every location. With `prog_ok` low the array is unchanged, but the pulse is still raised.
- R9: In word organization, word w has its low byte at byte address 2w and its high byte at 2w+1.
- R10: `doe` is low whenever chip select is low and outside a read. `dout` is 0 whenever `doe` is low. `cmd_valid` lasts one cycle and comes only in the cycle after chip select is sampled falling.
- R11: A chip select fall before a command is complete drops the command and returns to start-bit search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| org | input | 1 | Organization: 0 bytes, 1 words |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| prog_ok | input | 1 | Controller allows the array to change |
| dout | output | 1 | Serial data out |
| doe | output | 1 | Output enable for dout |
| cmd_valid | output | 1 | One-cycle pulse for a committed command |
| cmd_code | output | 3 | Committed command code |
| cmd_addr | output | 9 | Committed address (x16: bit 8 is zero) |
| cmd_data | output | 16 | Committed data |

## Verification
The case that is hardest to reach from the ports is a sequential read that crosses the top of the array. The stimulus first stores a known value at location 0. It then starts a read at the last byte or word and keeps chip select high through two full words, so the wrap and the missing second dummy bit can both be observed. A second hard case is rejecting commands by edge count. The bench sends writes with one serial clock edge too many and one too few, then reads the target location back to show that the array did not change.

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front #(
  parameter int ABITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             org,
  input  logic             cs,
  input  logic             sck,
  input  logic             di,
  input  logic             prog_ok,
  output logic             dout,
  output logic             doe,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [ABITS-1:0] cmd_addr,
  output logic [15:0]      cmd_data
);
  localparam int DEPTH = 1 << ABITS;
  localparam logic [2:0] C_WRITE = 3'd1, C_ERASE = 3'd2, C_ERAL = 3'd3,
                         C_WRAL = 3'd4, C_EWEN = 3'd5, C_EWDS = 3'd6, C_READ = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_END, S_RD} st_t;

  logic [7:0]       mem [DEPTH];
  st_t              st;
  logic             cs_d, sck_d;
  logic [5:0]       cnt;
  logic [ABITS:0]   hs;
  logic [15:0]      ds, rs;
  logic [2:0]       code, dec;
  logic [ABITS-1:0] adr, raddr;
  logic [4:0]       rbit;

  wire rise = cs & sck & ~sck_d;
  wire fall = cs_d & ~cs;

  wire [5:0] aw    = org ? 6'(ABITS - 1) : 6'(ABITS);
  wire [5:0] dw    = org ? 6'd16 : 6'd8;
  wire [5:0] hlast = aw + 6'd2;
  wire [5:0] dlast = aw + dw + 6'd2;
  wire [5:0] want  = (code == C_WRITE || code == C_WRAL) ? dlast + 6'd1 : hlast + 6'd1;

  wire [ABITS+1:0] nh  = {hs, di};
  wire [1:0]       op  = org ? nh[ABITS:ABITS-1]   : nh[ABITS+1:ABITS];
  wire [1:0]       ext = org ? nh[ABITS-2:ABITS-3] : nh[ABITS-1:ABITS-2];
  wire [ABITS-1:0] na  = org ? {1'b0, nh[ABITS-2:0]} : nh[ABITS-1:0];

  wire [ABITS-1:0] wlo  = {raddr[ABITS-2:0], 1'b0};
  wire [ABITS-1:0] whi  = {raddr[ABITS-2:0], 1'b1};
  wire [15:0]      fw   = org ? {mem[whi], mem[wlo]} : {mem[raddr], 8'h00};
  wire [ABITS-1:0] rinc = org ? {1'b0, raddr[ABITS-2:0] + (ABITS-1)'(1)} : raddr + ABITS'(1);

  wire commit = fall && st == S_END && cnt == want;

  always_comb begin
    case (op)
      2'b10:   dec = C_READ;
      2'b01:   dec = C_WRITE;
      2'b11:   dec = C_ERASE;
      default:
        case (ext)
          2'b11:   dec = C_EWEN;
          2'b00:   dec = C_EWDS;
          2'b10:   dec = C_ERAL;
          default: dec = C_WRAL;
        endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_d <= 1'b0; sck_d <= 1'b0; cnt <= '0; hs <= '0;
      ds <= '0; rs <= '0; code <= '0; adr <= '0; raddr <= '0; rbit <= '0;
      dout <= 1'b0; doe <= 1'b0; cmd_valid <= 1'b0;
      cmd_code <= '0; cmd_addr <= '0; cmd_data <= '0;
    end else begin
      cs_d      <= cs;
      sck_d     <= sck;
      cmd_valid <= 1'b0;
      if (!cs) begin
        st <= S_IDLE; doe <= 1'b0; dout <= 1'b0; rbit <= '0;
        if (commit) begin
          cmd_valid <= 1'b1;
          cmd_code  <= code;
          cmd_addr  <= adr;
          cmd_data  <= org ? ds : {8'h00, ds[7:0]};
        end
      end else if (rise) begin
        case (st)
          S_IDLE: if (di) begin st <= S_HDR; cnt <= 6'd1; hs <= '0; end
          S_HDR: begin
            hs  <= nh[ABITS:0];
            cnt <= cnt + 6'd1;
            if (cnt == hlast) begin
              code <= dec; adr <= na; raddr <= na; ds <= '0;
              if (dec == C_READ) begin
                st <= S_RD; doe <= 1'b1; dout <= 1'b0; rbit <= '0;
              end else if (dec == C_WRITE || dec == C_WRAL) st <= S_DATA;
              else st <= S_END;
            end
          end
          S_DATA: begin
            ds  <= {ds[14:0], di};
            cnt <= cnt + 6'd1;
            if (cnt == dlast) st <= S_END;
          end
          S_END: if (cnt != 6'd63) cnt <= cnt + 6'd1;
          S_RD: begin
            if (rbit == 5'd0) begin
              dout  <= fw[15];
              rs    <= {fw[14:0], 1'b0};
              rbit  <= 5'(dw - 6'd1);
              raddr <= rinc;
            end else begin
              dout <= rs[15];
              rs   <= {rs[14:0], 1'b0};
              rbit <= rbit - 5'd1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit && prog_ok) begin
      case (code)
        C_WRITE:
          if (org) begin
            mem[{adr[ABITS-2:0], 1'b0}] <= ds[7:0];
            mem[{adr[ABITS-2:0], 1'b1}] <= ds[15:8];
          end else mem[adr] <= ds[7:0];
        C_ERASE:
          if (org) begin
            mem[{adr[ABITS-2:0], 1'b0}] <= 8'hFF;
            mem[{adr[ABITS-2:0], 1'b1}] <= 8'hFF;
          end else mem[adr] <= 8'hFF;
        C_ERAL:
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        C_WRAL:
          for (int i = 0; i < DEPTH; i++)
            mem[i] <= mem[i] & ((org && i[0]) ? ds[15:8] : ds[7:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_front_chk.sv
module mw_eeprom_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       dout,
  input logic       doe,
  input logic       cmd_valid,
  input logic [2:0] cmd_code
);
  a_r10_doe_off_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !doe);
  a_r10_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !doe |-> !dout);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r7_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!$past(cs) && $past(cs, 2)));
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code >= 3'd1 && cmd_code <= 3'd6));
  a_r5_doe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> $past(cs));
endmodule

bind mw_eeprom_front mw_eeprom_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .doe(doe),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code)
);

// File: tb/sim_mw_eeprom_front.sv
module sim_mw_eeprom_front;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, org = 0, cs = 0, sck = 0, di = 0, prog_ok = 0;
  logic dout, doe, cmd_valid;
  logic [2:0] cmd_code;
  logic [8:0] cmd_addr;
  logic [15:0] cmd_data;

  int nchk = 0, nfail = 0, ncmd = 0;
  logic [2:0] lcode;
  logic [8:0] laddr;
  logic [15:0] ldata;
  bit done = 0;

  mw_eeprom_front u0 (.clk(clk), .rst_n(rst_n), .org(org), .cs(cs), .sck(sck), .di(di),
    .prog_ok(prog_ok), .dout(dout), .doe(doe), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (cmd_valid) begin
    ncmd++; lcode = cmd_code; laddr = cmd_addr; ldata = cmd_data;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic b, output logic q);
    di = b;
    repeat (2) @(negedge clk);
    sck = 1;
    repeat (3) @(negedge clk);
    q = dout;
    sck = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_on();
    cs = 1; sck = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    cs = 0; di = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic hdr(input logic o, input logic [1:0] op, input logic [8:0] a, output logic q);
    logic z;
    xfer(1, z); xfer(op[1], z); xfer(op[0], z);
    for (int i = (o ? 7 : 8); i >= 0; i--) xfer(a[i], q);
  endtask

  task automatic get_word(input logic o, output logic [15:0] w);
    logic q;
    w = '0;
    for (int i = 0; i < (o ? 16 : 8); i++) begin xfer(0, q); w = {w[14:0], q}; end
  endtask

  task automatic rd(input string tag, input logic o, input logic [8:0] a, output logic [15:0] w);
    logic q;
    org = o; cs_on();
    hdr(o, 2'b10, a, q);
    check({tag, " R5 dummy bit"}, {15'd0, q}, 16'd0);
    check({tag, " R5 doe high"}, {15'd0, doe}, 16'd1);
    get_word(o, w);
    cs_off();
  endtask

  task automatic prog(input logic o, input logic [1:0] op, input logic [8:0] a,
                      input logic hasd, input logic [15:0] d, input int delta);
    logic q;
    int n;
    org = o; cs_on();
    hdr(o, op, a, q);
    if (hasd) begin
      n = (o ? 16 : 8) + (delta < 0 ? delta : 0);
      for (int i = 0; i < n; i++) xfer(d[(o ? 15 : 7) - i], q);
    end
    if (delta > 0) for (int i = 0; i < delta; i++) xfer(0, q);
    cs_off();
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R1 doe after reset", {15'd0, doe}, 16'd0);
    check("R1 cmd_valid after reset", {15'd0, cmd_valid}, 16'd0);
    rd("R1", 1, 9'd0, w);
    check("R1 word 0 erased", w, 16'hFFFF);
    rd("R1", 0, 9'd300, w);
    check("R1 byte 300 erased", w, 16'h00FF);
  endtask

  task automatic t_write();
    logic [15:0] w;
    int c0;
    prog_ok = 1; c0 = ncmd;
    prog(1, 2'b01, 9'd5, 1, 16'hA55A, 0);
    check("R7 write committed", 16'(ncmd - c0), 16'd1);
    check("R3 write code", {13'd0, lcode}, 16'd1);
    check("R4 x16 address", {7'd0, laddr}, 16'd5);
    check("R4 x16 data", ldata, 16'hA55A);
    rd("R8", 1, 9'd5, w);
    check("R8 word 5 written", w, 16'hA55A);
    rd("R9", 0, 9'd10, w);
    check("R9 low byte at 2w", w, 16'h005A);
    rd("R9", 0, 9'd11, w);
    check("R9 high byte at 2w+1", w, 16'h00A5);
  endtask

  task automatic t_start();
    logic [15:0] w;
    logic q;
    org = 0; cs_on();
    xfer(0, q); xfer(0, q); xfer(0, q);
    check("R2 no output during search", {15'd0, doe}, 16'd0);
    hdr(0, 2'b10, 9'd10, q);
    check("R2 dummy after leading zeros", {15'd0, q}, 16'd0);
    get_word(0, w);
    cs_off();
    check("R2 read after leading zeros", w, 16'h005A);
  endtask

  task automatic t_seq();
    logic [15:0] w;
    logic q;
    prog(0, 2'b01, 9'd0, 1, 16'h003C, 0);
    check("R4 x8 data field", ldata, 16'h003C);
    org = 0; cs_on();
    hdr(0, 2'b10, 9'd511, q);
    get_word(0, w);
    check("R6 byte 511", w, 16'h00FF);
    get_word(0, w);
    check("R6 wrap to byte 0 no dummy", w, 16'h003C);
    cs_off();
    prog(1, 2'b01, 9'd255, 1, 16'h1234, 0);
    org = 1; cs_on();
    hdr(1, 2'b10, 9'd255, q);
    get_word(1, w);
    check("R6 word 255", w, 16'h1234);
    get_word(1, w);
    check("R6 wrap to word 0 no dummy", w, 16'hFF3C);
    cs_off();
    check("R10 doe low after cs fall", {15'd0, doe}, 16'd0);
  endtask

  task automatic t_count();
    logic [15:0] w;
    int c0;
    c0 = ncmd;
    prog(1, 2'b01, 9'd5, 1, 16'h0000, 1);
    check("R7 one edge too many", 16'(ncmd - c0), 16'd0);
    prog(1, 2'b01, 9'd5, 1, 16'h0000, -1);
    check("R7 one edge too few", 16'(ncmd - c0), 16'd0);
    prog(0, 2'b11, 9'd10, 0, 16'h0, 1);
    check("R7 erase too long", 16'(ncmd - c0), 16'd0);
    rd("R7", 1, 9'd5, w);
    check("R7 word 5 untouched", w, 16'hA55A);
  endtask

  task automatic t_abort();
    logic [15:0] w;
    logic q;
    int c0;
    c0 = ncmd;
    org = 1; cs_on();
    xfer(1, q); xfer(0, q); xfer(1, q); xfer(0, q); xfer(0, q);
    cs_off();
    check("R11 aborted header no command", 16'(ncmd - c0), 16'd0);
    org = 1; cs_on();
    hdr(1, 2'b10, 9'd5, q);
    xfer(0, q); xfer(0, q);
    cs_off();
    check("R10 doe low after read abort", {15'd0, doe}, 16'd0);
    check("R10 dout low after read abort", {15'd0, dout}, 16'd0);
    rd("R11", 0, 9'd10, w);
    check("R11 fresh read after abort", w, 16'h005A);
  endtask

  task automatic t_ext();
    logic [15:0] w;
    int c0;
    c0 = ncmd;
    prog(1, 2'b00, 9'h0C0, 0, 16'h0, 0);
    check("R3 enable code", {13'd0, lcode}, 16'd5);
    prog(1, 2'b00, 9'h000, 0, 16'h0, 0);
    check("R3 disable code", {13'd0, lcode}, 16'd6);
    check("R7 two short commands", 16'(ncmd - c0), 16'd2);
    prog(1, 2'b11, 9'd5, 0, 16'h0, 0);
    check("R3 erase code", {13'd0, lcode}, 16'd2);
    rd("R8", 1, 9'd5, w);
    check("R8 erase sets ones", w, 16'hFFFF);
    prog(0, 2'b00, 9'h100, 0, 16'h0, 0);
    check("R3 erase all code", {13'd0, lcode}, 16'd3);
    rd("R8", 1, 9'd255, w);
    check("R8 erase all word 255", w, 16'hFFFF);
    prog(1, 2'b01, 9'd3, 1, 16'h00FF, 0);
    prog(1, 2'b00, 9'h040, 1, 16'hF0F0, 0);
    check("R3 write all code", {13'd0, lcode}, 16'd4);
    check("R4 write all data", ldata, 16'hF0F0);
    rd("R8", 1, 9'd3, w);
    check("R8 write all ANDs", w, 16'h00F0);
    rd("R8", 1, 9'd7, w);
    check("R8 write all fills", w, 16'hF0F0);
    prog_ok = 0; c0 = ncmd;
    prog(1, 2'b01, 9'd7, 1, 16'h1111, 0);
    check("R8 pulse without permission", 16'(ncmd - c0), 16'd1);
    rd("R8", 1, 9'd7, w);
    check("R8 blocked write", w, 16'hF0F0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_start();
    t_seq();
    t_count();
    t_abort();
    t_ext();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule